// File: doc/BRIEF.md
# External Interrupt Input Unit

This unit takes four asynchronous interrupt pins and turns them into one prioritised interrupt request for a processor core. Every pin is brought into the clock domain by a two-stage synchroniser. A per-channel trigger detector then watches the synchronised level for the condition selected in that channel's trigger-mode field. When the condition occurs, the detector sets a sticky pending flag. The enabled pending flags go to a fixed-priority encoder. The encoder drives a registered request line and the entry address of the winning channel.

Channels 0 and 1 can trigger on either edge direction or on either level. Channels 2 and 3 can trigger on a rising edge, a falling edge or any change, but not on a level. Channel 3 has a sampling glitch filter, and software picks its sample rate as every cycle, every 16th cycle or every 64th cycle. One clock cycle counts as one instruction cycle. Events on channels 2 and 3 also produce a one-cycle count pulse for an event timer, whether or not the channel's interrupt is enabled.

Top module: `extirq_unit`

## Requirements
- R1: A pin change that is set up before rising clock edge 1 sets the channel's pending flag at edge 3. For an enabled channel, `irq_req` rises at edge 4 and not before.
- R2: Channels 0 and 1 accept these trigger-mode codes: 3'b001 for a rising edge, 3'b010 for a falling edge, 3'b100 for a high level and 3'b101 for a low level.
- R3: Channels 2 and 3 accept these trigger-mode codes: 3'b001 for a rising edge, 3'b010 for a falling edge and 3'b011 for any change. A rising edge sets nothing in falling-edge mode.
- R4: A code that a channel does not support disables detection on that channel, and so does 3'b000, 3'b110 or 3'b111. The unsupported codes are 3'b011 on channels 0 and 1, and 3'b100 and 3'b101 on channels 2 and 3. A disabled channel sets no pending flag and produces no timer pulse.
- R5: A pending flag stays set until its `pend_clr` bit is pulsed. The pulse clears the flag at the next edge, and `irq_req` falls one edge later. In level mode the flag is set again on every cycle while the level persists, and this wins over a clear.
- R6: When several enabled flags are pending, channel 0 wins and channel 3 loses to all others. `irq_vec` is 8'h03, 8'h0B, 8'h13 or 8'h1B for channel 0, 1, 2 or 3, and 8'h00 when no request is active.
- R7: `irq_en[i]` masks only the request: a flag that is pending while masked is kept, and `irq_req` rises one edge after the enable bit is set.
- R8: On channels 0 to 2, a high or low pulse of one clock cycle is caught.
- R9: On channel 3, `flt_div` selects the sample period N: 2'b00 gives N=1, 2'b01 gives N=16, and 2'b10 or 2'b11 gives N=64. The filter takes a new level after two consecutive equal samples. A pulse of 2N cycles is therefore accepted, and a pulse shorter than N cycles (1 cycle when N=1) is rejected.
- R10: `tmr_evt` is high for one cycle, at the same edge that sets the pending flag, for every event that channel 2 or 3 detects. This holds whatever the state of `irq_en`.
- R11: After reset, `irq_req`, `irq_vec` and `tmr_evt` are 0 and all pending flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 4 | Asynchronous interrupt pins, bit i is channel i |
| trg_mode | input | 12 | Trigger-mode codes, bits [3i+2:3i] for channel i |
| irq_en | input | 4 | Per-channel request enable |
| pend_clr | input | 4 | Per-channel pending-flag clear pulse |
| flt_div | input | 2 | Channel 3 filter sample-period select |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | 8 | Registered entry address of the winning channel |
| tmr_evt | output | 1 | Registered event-timer count pulse |

## Verification
Inputs change just after a falling edge, and outputs are read at a later falling edge, so each rising edge is counted. On the unfiltered channels, `tmr_evt` is due at the third rising edge after a pin change and `irq_req`/`irq_vec` at the fourth. The bench checks that the request is still low at the third edge and present at the fourth. A clear takes effect on `irq_req` two edges after the pulse, and an enable one edge after it is set. Channel 3 depends on the phase of the prescaler, so its results are checked after a window of 3N+10 cycles, which covers the worst-case acceptance delay.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  localparam int TRG_W = 3;

  typedef enum logic [TRG_W-1:0] {
    TRG_OFF  = 3'b000,
    TRG_RISE = 3'b001,
    TRG_FALL = 3'b010,
    TRG_ANY  = 3'b011,
    TRG_HIGH = 3'b100,
    TRG_LOW  = 3'b101
  } trg_e;

  typedef enum logic [1:0] {
    DIV_ONE = 2'b00,
    DIV_MID = 2'b01,
    DIV_TOP = 2'b10
  } div_e;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/extirq_filter.sv
module extirq_filter import extirq_pkg::*; #(
  parameter int DIV_M = 16,
  parameter int DIV_H = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       din,
  output logic       dout
);
  localparam int CW = (DIV_H > 2) ? $clog2(DIV_H) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          strobe;
  logic          last_q;

  // sample period minus one for the selected rate
  always_comb begin
    case (sel)
      DIV_ONE: lim = '0;
      DIV_MID: lim = CW'(DIV_M - 1);
      default: lim = CW'(DIV_H - 1);
    endcase
  end

  // >= keeps the counter bounded when the rate is lowered on the fly
  assign strobe = (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
      dout   <= 1'b0;
    end else begin
      cnt_q <= strobe ? '0 : cnt_q + 1'b1;
      if (strobe) begin
        last_q <= din;
        if (din == last_q) dout <= din;
      end
    end
  end
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect import extirq_pkg::*; #(
  parameter bit LEVEL_OK = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl,
  input  logic [TRG_W-1:0] mode,
  input  logic             clr,
  output logic             evt,
  output logic             pend
);
  logic prev_q;

  // level-capable channels lose the any-change mode, edge-only ones the levels
  always_comb begin
    case (mode)
      TRG_RISE: evt = lvl & ~prev_q;
      TRG_FALL: evt = ~lvl & prev_q;
      TRG_ANY:  evt = LEVEL_OK ? 1'b0 : (lvl ^ prev_q);
      TRG_HIGH: evt = LEVEL_OK ? lvl : 1'b0;
      TRG_LOW:  evt = LEVEL_OK ? ~lvl : 1'b0;
      default:  evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= lvl;
      pend   <= evt | (pend & ~clr);
    end
  end
endmodule

// File: rtl/extirq_prio.sv
module extirq_prio #(
  parameter int N        = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  output logic             irq,
  output logic [VEC_W-1:0] vec
);
  logic             hit;
  logic [VEC_W-1:0] win;

  // scan from the weakest channel so the lowest index is written last
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        win = VEC_W'(VEC_BASE + VEC_STEP * i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      vec <= '0;
    end else begin
      irq <= hit;
      vec <= win;
    end
  end
endmodule

// File: rtl/extirq_unit.sv
module extirq_unit import extirq_pkg::*; #(
  parameter int              N_CH       = 4,
  parameter logic [N_CH-1:0] LEVEL_MASK = 4'b0011,
  parameter logic [N_CH-1:0] TMR_MASK   = 4'b1100,
  parameter int              FLT_CH     = 3,
  parameter int              DIV_M      = 16,
  parameter int              DIV_H      = 64,
  parameter int              VEC_W      = 8,
  parameter int              VEC_BASE   = 3,
  parameter int              VEC_STEP   = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_CH-1:0]       pin_in,
  input  logic [N_CH*TRG_W-1:0] trg_mode,
  input  logic [N_CH-1:0]       irq_en,
  input  logic [N_CH-1:0]       pend_clr,
  input  logic [1:0]            flt_div,
  output logic                  irq_req,
  output logic [VEC_W-1:0]      irq_vec,
  output logic                  tmr_evt
);
  logic [N_CH-1:0] pin_s;
  logic [N_CH-1:0] lvl;
  logic [N_CH-1:0] evt;
  logic [N_CH-1:0] pend_q;

  extirq_sync #(.W(N_CH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    if (i == FLT_CH) begin : g_flt
      extirq_filter #(.DIV_M(DIV_M), .DIV_H(DIV_H)) u_flt (
        .clk  (clk),
        .rst  (rst),
        .sel  (flt_div),
        .din  (pin_s[i]),
        .dout (lvl[i])
      );
    end else begin : g_raw
      assign lvl[i] = pin_s[i];
    end

    extirq_detect #(.LEVEL_OK(LEVEL_MASK[i])) u_det (
      .clk  (clk),
      .rst  (rst),
      .lvl  (lvl[i]),
      .mode (trg_mode[i*TRG_W +: TRG_W]),
      .clr  (pend_clr[i]),
      .evt  (evt[i]),
      .pend (pend_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) tmr_evt <= 1'b0;
    else     tmr_evt <= |(evt & TMR_MASK);
  end

  extirq_prio #(
    .N        (N_CH),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_prio (
    .clk (clk),
    .rst (rst),
    .req (pend_q & irq_en),
    .irq (irq_req),
    .vec (irq_vec)
  );
endmodule

// File: rtl/extirq_chk.sv
module extirq_chk #(
  parameter int N_CH  = 4,
  parameter int VEC_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [N_CH-1:0]   irq_en,
  input logic [N_CH-1:0]   pend,
  input logic [N_CH*3-1:0] trg_mode,
  input logic              irq_req,
  input logic [VEC_W-1:0]  irq_vec,
  input logic              tmr_evt
);
  function automatic logic edge_code(input logic [2:0] m);
    return (m == 3'b001) || (m == 3'b010) || (m == 3'b011);
  endfunction

  function automatic logic lvl_ch_code(input logic [2:0] m);
    return (m == 3'b001) || (m == 3'b010) || (m == 3'b100) || (m == 3'b101);
  endfunction

  // R6
  vec_shape_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec[2:0] == 3'b011) && (irq_vec < VEC_W'(32)));

  // R6
  idle_vec_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_vec == '0));

  // R7
  req_tracks_pend_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_req == (|($past(pend & irq_en)))));

  // R6
  top_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pend[0] & irq_en[0])) |-> (irq_vec == VEC_W'(3)));

  // R10
  tmr_source_chk: assert property (@(posedge clk) disable iff (rst)
    (tmr_evt && !$past(rst)) |-> $past(edge_code(trg_mode[8:6]) || edge_code(trg_mode[11:9])));

  // R4
  ch0_legal_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(pend[0]) && !$past(rst)) |-> $past(lvl_ch_code(trg_mode[2:0])));
endmodule

bind extirq_unit extirq_chk #(.N_CH(N_CH), .VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq_en   (irq_en),
  .pend     (pend_q),
  .trg_mode (trg_mode),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec),
  .tmr_evt  (tmr_evt)
);

// File: tb/tb_extirq_unit.sv
module tb_extirq_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pin = '0;
  logic [11:0] mode = '0;
  logic [3:0]  en = '0;
  logic [3:0]  clr = '0;
  logic [1:0]  fsel = '0;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic        tmr_evt;

  int total = 0;
  int bad = 0;
  int evt_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  extirq_unit dut (
    .clk      (clk),
    .rst      (rst),
    .pin_in   (pin),
    .trg_mode (mode),
    .irq_en   (en),
    .pend_clr (clr),
    .flt_div  (fsel),
    .irq_req  (irq_req),
    .irq_vec  (irq_vec),
    .tmr_evt  (tmr_evt)
  );

  always @(negedge clk) if (!rst && tmr_evt) evt_cnt++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input int ch, input logic [2:0] code);
    mode[ch*3 +: 3] = code;
  endtask

  task automatic clr_all();
    clr = 4'hF;
    step(1);
    clr = '0;
    step(2);
  endtask

  function automatic logic [7:0] exp_vec(input logic [3:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) return 8'(3 + 8 * i);
    return 8'h00;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    int n;
    int w;
    logic [3:0] m;
    logic [3:0] e;
    void'($urandom(32'd4242));
    step(3);
    rst = 1'b0;
    chk(irq_req, 0, "R11 req after reset");
    chk(irq_vec, 0, "R11 vec after reset");
    chk(tmr_evt, 0, "R11 tmr after reset");
    en = 4'hF;
    step(3);
    chk(irq_req, 0, "R11 nothing pending");

    // R1 / R2 rising edge on channel 0, exact latency
    set_mode(0, 3'b001);
    pin[0] = 1'b1;
    step(3);
    chk(irq_req, 0, "R1 not yet at edge 3");
    step(1);
    chk(irq_req, 1, "R1 req at edge 4");
    chk(irq_vec, 8'h03, "R2 rise vec ch0");
    step(5);
    chk(irq_req, 1, "R5 sticky");
    clr_all();
    chk(irq_req, 0, "R5 cleared");

    // R2 falling edge ch0
    set_mode(0, 3'b010);
    pin[0] = 1'b0;
    step(4);
    chk(irq_vec, 8'h03, "R2 fall ch0");
    clr_all();

    // R2 / R5 high level ch1
    set_mode(0, 3'b000);
    set_mode(1, 3'b100);
    pin[1] = 1'b1;
    step(4);
    chk(irq_vec, 8'h0B, "R2 high ch1");
    clr = 4'b0010;
    step(1);
    clr = '0;
    step(2);
    chk(irq_req, 1, "R5 level resets flag");
    pin[1] = 1'b0;
    step(4);
    clr_all();
    chk(irq_req, 0, "R5 level gone then cleared");

    // R2 low level ch1
    set_mode(1, 3'b101);
    step(4);
    chk(irq_vec, 8'h0B, "R2 low ch1");
    pin[1] = 1'b1;
    step(4);
    clr_all();
    chk(irq_req, 0, "R2 low level released");

    // R4 unsupported codes
    base = evt_cnt;
    set_mode(0, 3'b011);
    set_mode(1, 3'b011);
    pin[0] = 1'b1; step(3); pin[0] = 1'b0; step(3);
    pin[1] = 1'b0; step(3); pin[1] = 1'b1; step(3);
    step(4);
    chk(irq_req, 0, "R4 any-change on ch0/ch1");
    set_mode(0, 3'b110);
    set_mode(1, 3'b111);
    pin[0] = 1'b1; step(3); pin[1] = 1'b0; step(6);
    chk(irq_req, 0, "R4 codes 110/111");
    set_mode(2, 3'b100);
    pin[2] = 1'b1;
    step(8);
    set_mode(2, 3'b101);
    pin[2] = 1'b0;
    step(8);
    chk(irq_req, 0, "R4 level on ch2");
    chk(evt_cnt - base, 0, "R4 no timer pulse");
    mode = '0;
    pin = '0;
    step(4);
    clr_all();

    // R3 / R10 channel 2 edges
    set_mode(2, 3'b001);
    pin[2] = 1'b1;
    step(3);
    chk(tmr_evt, 1, "R10 tmr at edge 3");
    step(1);
    chk(tmr_evt, 0, "R10 tmr one cycle");
    chk(irq_vec, 8'h13, "R3 rise ch2");
    clr_all();
    set_mode(2, 3'b011);
    pin[2] = 1'b0;
    step(4);
    chk(irq_vec, 8'h13, "R3 any-change fall ch2");
    clr_all();
    pin[2] = 1'b1;
    step(4);
    chk(irq_vec, 8'h13, "R3 any-change rise ch2");
    clr_all();
    set_mode(2, 3'b010);
    pin[2] = 1'b0;
    step(4);
    chk(irq_req, 1, "R3 fall ch2");
    clr_all();
    pin[2] = 1'b1;
    step(4);
    chk(irq_req, 0, "R3 rise ignored in fall mode");

    // R10 / R7 masked channel still counts and keeps its flag
    en = '0;
    base = evt_cnt;
    pin[2] = 1'b0;
    step(4);
    chk(irq_req, 0, "R7 masked");
    step(2);
    chk(evt_cnt - base, 1, "R10 pulse while masked");
    en = 4'hF;
    step(1);
    chk(irq_vec, 8'h13, "R7 pending kept under mask");
    clr_all();

    // R8 one-cycle pulses
    set_mode(1, 3'b001);
    pin[1] = 1'b1; step(1); pin[1] = 1'b0;
    step(4);
    chk(irq_vec, 8'h0B, "R8 1-cycle high ch1");
    clr_all();
    set_mode(2, 3'b000);
    pin[2] = 1'b1;
    step(4);
    set_mode(2, 3'b010);
    pin[2] = 1'b0; step(1); pin[2] = 1'b1;
    step(4);
    chk(irq_vec, 8'h13, "R8 1-cycle low ch2");
    clr_all();
    mode = '0;
    pin = '0;
    step(4);
    clr_all();

    // R9 channel 3 filter at each rate
    set_mode(3, 3'b011);
    for (int s = 0; s < 4; s++) begin
      fsel = 2'(s);
      n = (s == 0) ? 1 : (s == 1) ? 16 : 64;
      w = (n == 1) ? 1 : n - 1;
      step(2 * n + 4);
      clr_all();
      base = evt_cnt;
      pin[3] = 1'b1; step(w); pin[3] = 1'b0;
      step(3 * n + 10);
      chk(irq_req, 0, $sformatf("R9 short pulse rejected N=%0d", n));
      chk(evt_cnt - base, 0, $sformatf("R9 no timer on reject N=%0d", n));
      pin[3] = 1'b1; step(2 * n); pin[3] = 1'b0;
      step(3 * n + 10);
      chk(irq_vec, 8'h1B, $sformatf("R9 pulse accepted N=%0d", n));
      chk(evt_cnt - base, 2, $sformatf("R10 two edges ch3 N=%0d", n));
      clr_all();
    end

    // R6 random pending and enable patterns
    fsel = 2'b00;
    mode = {3'b001, 3'b001, 3'b001, 3'b001};
    pin = '0;
    step(6);
    clr_all();
    for (int k = 0; k < 24; k++) begin
      m = 4'($urandom % 16);
      e = 4'($urandom % 16);
      if (k == 0) begin m = 4'hF; e = 4'hF; end
      if (k == 1) begin m = 4'b1100; e = 4'b1110; end
      en = e;
      pin = m;
      step(10);
      chk(irq_req, |(m & e), "R6 request");
      chk(irq_vec, exp_vec(m & e), "R6 priority vector");
      pin = '0;
      step(10);
      clr_all();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule